// File: doc/BRIEF.md
# Audio Frame Sync Generator

This block produces the timing skeleton of a two-channel serial audio port. It derives a bit-clock enable, then counts bit clocks into frames and drives a transmit frame sync, a receive frame sync and a one-cycle start-of-frame strobe. The frame length and the active sync width are programmed as counts minus one. For 16-bit stereo, a frame length of 31 and a width of 15 give a 50% duty sync that also serves as a left/right clock.

The bit clock comes from one of two sources. One is an integer divider on the system clock. The other is an external bit clock that is already synchronous to the system clock. The frame sync can be generated inside the block, either back to back or only after a transmit word load. It can also be taken from an external codec, which is then re-driven with the programmed polarities. The clock source and the sync generator have separate enables. The sync generator only runs while the clock source runs.

Top module: `audio_fsync_gen`

## Requirements
- R1: With `cfg_mode` = 00, `clk_gen_en` high and divider value D, `bclk_en` is high for one cycle out of every D+1. The first pulse appears D+1 cycles after enabling. A divider lowered on the fly never stalls the count.
- R2: With `cfg_mode` = 01, 10 or 11, each rising edge sampled on `ext_bclk` gives one `bclk_en` pulse of one cycle, in the cycle after that edge is sampled.
- R3: An internally generated frame lasts `cfg_frame_len`+1 bit clocks. `sof` pulses for one cycle, one cycle after the `bclk_en` pulse that opens a frame. With `cfg_free_run` = 1, frames follow each other with no gap.
- R4: The internal sync is active for the first `cfg_sync_width`+1 bit clocks of each frame and inactive for the rest.
- R5: If the width is greater than or equal to the frame length, the sync is inactive for exactly one bit clock per frame. A frame length of 0 acts as 1.
- R6: With `cfg_free_run` = 0, a frame starts only after a `tx_load` pulse. A load during a frame starts the next frame straight after it. With no load pending, the sync stays inactive and `sof` stays low.
- R7: Frame length and width written during a frame first apply to the following frame.
- R8: `fsx` equals the active-high sync XOR `cfg_tx_low`, and `fsr` equals it XOR `cfg_rx_low`. A polarity bit of 1 selects active low.
- R9: With `clk_gen_en` low there are no `bclk_en` pulses, the sync is inactive and `sof` is low. With `fs_gen_en` low the sync is inactive and `sof` is low. After reset all of these are idle.
- R10: With `cfg_mode` = 10 or 11, `ext_fsync` is decoded with `cfg_rx_low` and sampled on each bit clock. The sync follows it one cycle after the `bclk_en` pulse. `sof` pulses when the decoded sync turns active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 00 internal clock and sync, 01 external clock with internal sync, 10/11 external clock and sync |
| cfg_clk_div | input | DIV_W | Bit-clock divider minus one |
| cfg_frame_len | input | PER_W | Bit clocks per frame minus one |
| cfg_sync_width | input | PER_W | Active sync bit clocks minus one |
| cfg_free_run | input | 1 | 1: sync every frame, 0: sync on transmit load |
| cfg_tx_low | input | 1 | Transmit sync active low |
| cfg_rx_low | input | 1 | Receive sync active low |
| clk_gen_en | input | 1 | Bit-clock source enable |
| fs_gen_en | input | 1 | Frame sync generator enable |
| tx_load | input | 1 | Transmit word loaded strobe |
| ext_bclk | input | 1 | External bit clock level, synchronous |
| ext_fsync | input | 1 | External frame sync pin level, synchronous |
| bclk_en | output | 1 | One-cycle bit-clock enable |
| fsx | output | 1 | Transmit frame sync, pin polarity |
| fsr | output | 1 | Receive frame sync, pin polarity |
| sof | output | 1 | Start-of-frame strobe |

## Verification
`bclk_en` is registered. It rises D+1 cycles after the divider is enabled from zero, or one cycle after a rising `ext_bclk` is sampled. The sync level and `sof` are registered one stage later, so they change one cycle after the `bclk_en` pulse they respond to. Polarity is applied without a further register. The bench drives inputs and samples outputs on the falling edge. It numbers samples from the first rising edge after the last drive, and it compares each sample against an expected value built from these latencies. So every check lands on the exact cycle a result is due, not on a window around it.

// File: rtl/afg_pkg.sv
package afg_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      MODE_INT_ALL = 2'b00,
      MODE_EXT_CLK = 2'b01,
      MODE_EXT_ALL = 2'b10,
      MODE_EXT_ALT = 2'b11
   } afg_mode_e;

   function automatic logic mode_ext_clk(input logic [1:0] m);
      return m != MODE_INT_ALL;
   endfunction

   function automatic logic mode_ext_sync(input logic [1:0] m);
      return m[1];
   endfunction
endpackage

// File: rtl/afg_bclk_src.sv
module afg_bclk_src #(
   parameter int DIV_W  = 8,
   parameter bit EXT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gen_en,
   input  logic [DIV_W-1:0] div,
   input  logic             ext_sel,
   input  logic             ext_bclk,
   output logic             bclk_en
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DIV_W-1:0] cnt;
   logic             int_hit;
   logic             ext_rise;
   logic             ext_sel_eff;

   assign int_hit     = (cnt >= div);
   assign ext_sel_eff = ext_sel & EXT_EN;

   generate
      if (EXT_EN) begin : g_ext
         logic ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= ext_bclk;
         end
         assign ext_rise = ext_bclk & ~ext_q;
      end else begin : g_noext
         assign ext_rise = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         bclk_en <= 1'b0;
      end else if (!gen_en) begin
         cnt     <= '0;
         bclk_en <= 1'b0;
      end else if (ext_sel_eff) begin
         cnt     <= '0;
         bclk_en <= ext_rise;
      end else begin
         bclk_en <= int_hit;
         cnt     <= int_hit ? '0 : cnt + 1'b1;
      end
   end

   // divider above zero never yields two adjacent pulses (R1)
   assert_div_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      bclk_en |=> (!bclk_en || $past(div) == '0 || $past(ext_sel_eff)));

   // a disabled source emits nothing (R9)
   assert_src_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_en |=> !bclk_en);
endmodule

// File: rtl/afg_frame.sv
module afg_frame #(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             tick,
   input  logic             free_run,
   input  logic             load,
   input  logic             ext_sel,
   input  logic             ext_act,
   input  logic [PER_W-1:0] period,
   input  logic [PER_W-1:0] width,
   output logic             sync,
   output logic             sof
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [PER_W-1:0] fcnt;
   logic [PER_W-1:0] fcnt_nxt;
   logic [PER_W-1:0] per_sh;
   logic [PER_W-1:0] wid_sh;
   logic [PER_W-1:0] per_eff;
   logic [PER_W-1:0] wid_eff;
   logic             active;
   logic             pend;
   logic             at_end;

   assign per_eff  = (period == '0) ? PER_W'(1) : period;
   assign wid_eff  = (width >= per_eff) ? per_eff - 1'b1 : width;
   assign fcnt_nxt = fcnt + 1'b1;
   assign at_end   = !active || (fcnt == per_sh);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt   <= '0;
         per_sh <= '0;
         wid_sh <= '0;
         active <= 1'b0;
         pend   <= 1'b0;
         sync   <= 1'b0;
         sof    <= 1'b0;
      end else if (!run_en) begin
         fcnt   <= '0;
         active <= 1'b0;
         pend   <= 1'b0;
         sync   <= 1'b0;
         sof    <= 1'b0;
      end else begin
         sof <= 1'b0;
         if (load) pend <= 1'b1;
         if (tick) begin
            if (ext_sel) begin
               active <= 1'b0;
               fcnt   <= '0;
               sync   <= ext_act;
               sof    <= ext_act & ~sync;
            end else if (at_end) begin
               if (free_run || pend || load) begin
                  active <= 1'b1;
                  fcnt   <= '0;
                  per_sh <= per_eff;
                  wid_sh <= wid_eff;
                  sync   <= 1'b1;
                  sof    <= 1'b1;
                  pend   <= 1'b0;
               end else begin
                  active <= 1'b0;
                  sync   <= 1'b0;
               end
            end else begin
               fcnt <= fcnt_nxt;
               sync <= (fcnt_nxt <= wid_sh);
            end
         end
      end
   end

   // a frame opens only on a bit-clock pulse (R3)
   assert_sof_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> $past(tick));

   // last bit clock of an internal frame is always inactive (R5)
   assert_sync_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !ext_sel && fcnt == per_sh) |-> !sync);

   // shadow copies only move when a frame opens (R7)
   assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sof |-> ($stable(per_sh) && $stable(wid_sh)));

   // disabled generator is quiet (R9)
   assert_frame_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!sync && !sof));
endmodule

// File: rtl/afg_pol.sv
module afg_pol (
   input  logic sync,
   input  logic ext_fsync,
   input  logic tx_low,
   input  logic rx_low,
   output logic fsx,
   output logic fsr,
   output logic ext_act
);
   timeunit 1ns;
   timeprecision 1ps;

   assign fsx     = sync ^ tx_low;
   assign fsr     = sync ^ rx_low;
   assign ext_act = ext_fsync ^ rx_low;
endmodule

// File: rtl/audio_fsync_gen.sv
module audio_fsync_gen
   import afg_pkg::*;
#(
   parameter int DIV_W  = 8,
   parameter int PER_W  = 8,
   parameter bit EXT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic [DIV_W-1:0] cfg_clk_div,
   input  logic [PER_W-1:0] cfg_frame_len,
   input  logic [PER_W-1:0] cfg_sync_width,
   input  logic             cfg_free_run,
   input  logic             cfg_tx_low,
   input  logic             cfg_rx_low,
   input  logic             clk_gen_en,
   input  logic             fs_gen_en,
   input  logic             tx_load,
   input  logic             ext_bclk,
   input  logic             ext_fsync,
   output logic             bclk_en,
   output logic             fsx,
   output logic             fsr,
   output logic             sof
);
   timeunit 1ns;
   timeprecision 1ps;

   generate
      if (DIV_W < 1 || PER_W < 2) begin : g_param_err
         $error("audio_fsync_gen: DIV_W must be >= 1 and PER_W >= 2");
      end
   endgenerate

   logic sel_ext_clk;
   logic sel_ext_sync;
   logic run_en;
   logic sync;
   logic ext_act;

   generate
      if (EXT_EN) begin : g_modes
         assign sel_ext_clk  = mode_ext_clk(cfg_mode);
         assign sel_ext_sync = mode_ext_sync(cfg_mode);
      end else begin : g_int_only
         assign sel_ext_clk  = 1'b0;
         assign sel_ext_sync = 1'b0;
      end
   endgenerate

   assign run_en = fs_gen_en & clk_gen_en;

   afg_bclk_src #(.DIV_W(DIV_W), .EXT_EN(EXT_EN)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen_en   (clk_gen_en),
      .div      (cfg_clk_div),
      .ext_sel  (sel_ext_clk),
      .ext_bclk (ext_bclk),
      .bclk_en  (bclk_en)
   );

   afg_frame #(.PER_W(PER_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .tick     (bclk_en),
      .free_run (cfg_free_run),
      .load     (tx_load),
      .ext_sel  (sel_ext_sync),
      .ext_act  (ext_act),
      .period   (cfg_frame_len),
      .width    (cfg_sync_width),
      .sync     (sync),
      .sof      (sof)
   );

   afg_pol u_pol (
      .sync      (sync),
      .ext_fsync (ext_fsync),
      .tx_low    (cfg_tx_low),
      .rx_low    (cfg_rx_low),
      .fsx       (fsx),
      .fsr       (fsr),
      .ext_act   (ext_act)
   );
endmodule

// File: tb/sim_audio_fsync_gen.sv
module sim_audio_fsync_gen;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_mode = 2'b00;
   logic [7:0] cfg_clk_div = 8'd0;
   logic [7:0] cfg_frame_len = 8'd31;
   logic [7:0] cfg_sync_width = 8'd15;
   logic       cfg_free_run = 1'b1;
   logic       cfg_tx_low = 1'b0;
   logic       cfg_rx_low = 1'b0;
   logic       clk_gen_en = 1'b0;
   logic       fs_gen_en = 1'b0;
   logic       tx_load = 1'b0;
   logic       ext_bclk = 1'b0;
   logic       ext_fsync = 1'b0;
   logic       bclk_en, fsx, fsr, sof;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic s_bclk [0:127];
   logic s_sof  [0:127];
   logic s_fsx  [0:127];
   logic s_fsr  [0:127];

   always #2.5 clk = ~clk;

   audio_fsync_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_clk_div(cfg_clk_div),
      .cfg_frame_len(cfg_frame_len), .cfg_sync_width(cfg_sync_width),
      .cfg_free_run(cfg_free_run), .cfg_tx_low(cfg_tx_low), .cfg_rx_low(cfg_rx_low),
      .clk_gen_en(clk_gen_en), .fs_gen_en(fs_gen_en), .tx_load(tx_load),
      .ext_bclk(ext_bclk), .ext_fsync(ext_fsync),
      .bclk_en(bclk_en), .fsx(fsx), .fsr(fsr), .sof(sof)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic grab(input int i);
      s_bclk[i] = bclk_en;
      s_sof[i]  = sof;
      s_fsx[i]  = fsx;
      s_fsr[i]  = fsr;
   endtask

   task automatic capture(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         grab(i);
      end
   endtask

   // frame pattern: sof at frame start, sync for wid+1 of per+1 bit clocks
   task automatic check_pattern(input int n, input int first, input int per,
                                input int wid, input string req);
      int bad = 0;
      int act = 0;
      int exp = 0;
      int bad_k = -1;
      for (int k = 0; k < n; k++) begin
         logic es, ef;
         int j;
         if (k < first) begin
            es = 1'b0; ef = 1'b0;
         end else begin
            j  = (k - first) % (per + 1);
            ef = (j == 0);
            es = (j <= wid);
         end
         if (s_sof[k] !== ef || s_fsr[k] !== (es ^ cfg_rx_low) || s_fsx[k] !== (es ^ cfg_tx_low)) begin
            if (bad == 0) begin
               bad_k = k;
               act = {s_sof[k], s_fsr[k], s_fsx[k]};
               exp = {ef, es ^ cfg_rx_low, es ^ cfg_tx_low};
            end
            bad++;
         end
      end
      chk(bad == 0, $sformatf("%s {sof,fsr,fsx} at sample %0d", req, bad_k), act, exp);
   endtask

   task automatic restart(input int per, input int wid, input bit free);
      @(negedge clk);
      cfg_frame_len  = 8'(per);
      cfg_sync_width = 8'(wid);
      cfg_free_run   = free;
      fs_gen_en      = 1'b0;
      @(negedge clk);
      fs_gen_en      = 1'b1;
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(bclk_en == 1'b0, "R9 reset bclk_en", bclk_en, 0);
      chk(sof == 1'b0, "R9 reset sof", sof, 0);
      chk(fsx == 1'b0, "R9 reset fsx", fsx, 0);
      chk(fsr == 1'b0, "R9 reset fsr", fsr, 0);
      rst_n = 1'b1;
   endtask

   task automatic t_divider;
      int bad = 0;
      int quiet = 0;
      @(negedge clk);
      cfg_clk_div = 8'd3;
      clk_gen_en  = 1'b1;
      capture(20);
      for (int k = 0; k < 20; k++) begin
         if (s_bclk[k] !== ((k % 4) == 3)) bad++;
         if (s_sof[k] !== 1'b0 || s_fsr[k] !== 1'b0) quiet++;
      end
      chk(bad == 0, "R1 divide-by-4 pulse train mismatches", bad, 0);
      chk(quiet == 0, "R9 sync generator disabled stays quiet", quiet, 0);
      cfg_clk_div = 8'd0;
      capture(4);
      bad = 0;
      for (int k = 1; k < 4; k++) if (s_bclk[k] !== 1'b1) bad++;
      chk(bad == 0, "R1 divider lowered to zero keeps pulsing", bad, 0);
   endtask

   task automatic t_free_run;
      restart(31, 15, 1'b1);
      capture(100);
      check_pattern(100, 0, 31, 15, "R3 R4 free-run 32/16");
      restart(7, 2, 1'b1);
      capture(24);
      check_pattern(24, 0, 7, 2, "R3 R4 free-run 8/3");
   endtask

   task automatic t_clamp;
      restart(5, 9, 1'b1);
      capture(24);
      check_pattern(24, 0, 5, 4, "R5 width clamp");
      restart(4, 4, 1'b1);
      capture(15);
      check_pattern(15, 0, 4, 3, "R5 width equal period");
      restart(0, 3, 1'b1);
      capture(10);
      check_pattern(10, 0, 1, 0, "R5 zero period");
   endtask

   task automatic t_polarity;
      cfg_tx_low = 1'b1;
      restart(3, 1, 1'b1);
      capture(16);
      check_pattern(16, 0, 3, 1, "R8 tx active low");
      chk(s_fsx[0] == 1'b0 && s_fsr[0] == 1'b1, "R8 first sync levels", {s_fsx[0], s_fsr[0]}, 1);
      cfg_tx_low = 1'b0;
      cfg_rx_low = 1'b1;
      restart(3, 1, 1'b1);
      capture(16);
      check_pattern(16, 0, 3, 1, "R8 rx active low");
      cfg_rx_low = 1'b0;
   endtask

   task automatic t_boundary;
      int bad = 0;
      restart(7, 3, 1'b1);
      for (int i = 0; i < 24; i++) begin
         @(negedge clk);
         grab(i);
         if (i == 3) begin
            cfg_frame_len  = 8'd3;
            cfg_sync_width = 8'd1;
         end
      end
      for (int k = 0; k < 24; k++) begin
         logic es, ef;
         if (k < 8) begin
            ef = (k == 0); es = (k <= 3);
         end else begin
            ef = (((k - 8) % 4) == 0); es = (((k - 8) % 4) <= 1);
         end
         if (s_sof[k] !== ef || s_fsr[k] !== es) bad++;
      end
      chk(bad == 0, "R7 mid-frame change deferred to next frame, mismatches", bad, 0);
   endtask

   task automatic t_load;
      int bad = 0;
      int idle = 0;
      restart(7, 2, 1'b0);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         grab(i);
         tx_load = (i == 5 || i == 8);
      end
      tx_load = 1'b0;
      for (int k = 0; k < 40; k++) begin
         logic es, ef;
         if (k >= 6 && k <= 21) begin
            ef = (((k - 6) % 8) == 0); es = (((k - 6) % 8) <= 2);
         end else begin
            ef = 1'b0; es = 1'b0;
         end
         if (s_sof[k] !== ef || s_fsr[k] !== es) bad++;
         if (k < 6 && (s_sof[k] !== 1'b0 || s_fsr[k] !== 1'b0)) idle++;
      end
      chk(idle == 0, "R6 no sync before load", idle, 0);
      chk(bad == 0, "R6 load-driven frames, mismatches", bad, 0);
      cfg_free_run = 1'b1;
   endtask

   task automatic t_enables;
      int bad = 0;
      restart(3, 1, 1'b1);
      capture(4);
      clk_gen_en = 1'b0;
      capture(8);
      for (int k = 0; k < 8; k++)
         if (s_bclk[k] !== 1'b0 || s_sof[k] !== 1'b0 || s_fsr[k] !== 1'b0) bad++;
      chk(bad == 0, "R9 clock source off silences all", bad, 0);
      clk_gen_en = 1'b1;
      capture(8);
      check_pattern(8, 1, 3, 1, "R9 restart after clock enable");
      fs_gen_en = 1'b0;
      capture(8);
      bad = 0;
      for (int k = 0; k < 8; k++)
         if (s_bclk[k] !== 1'b1 || s_sof[k] !== 1'b0 || s_fsr[k] !== 1'b0) bad++;
      chk(bad == 0, "R9 sync off while clock runs", bad, 0);
      fs_gen_en = 1'b1;
   endtask

   task automatic t_ext_clk;
      int bad = 0;
      @(negedge clk);
      cfg_mode = 2'b01;
      ext_bclk = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         grab(i);
         ext_bclk = ((i % 6) < 3);
      end
      for (int k = 0; k < 30; k++) if (s_bclk[k] !== ((k % 6) == 1)) bad++;
      chk(bad == 0, "R2 external bit clock edge pulses", bad, 0);
      clk_gen_en = 1'b0;
      bad = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (bclk_en !== 1'b0) bad++;
         ext_bclk = ((i % 4) < 2);
      end
      chk(bad == 0, "R9 external edges ignored while disabled", bad, 0);
      ext_bclk   = 1'b0;
      cfg_mode   = 2'b00;
      clk_gen_en = 1'b1;
   endtask

   function automatic logic ext_pin(input int i);
      return ((i >= 6 && i <= 13) || (i >= 22 && i <= 25)) ? 1'b0 : 1'b1;
   endfunction

   task automatic t_ext_sync;
      int bad = 0;
      int sofs = 0;
      logic m = 1'b0;
      @(negedge clk);
      cfg_mode   = 2'b10;
      cfg_rx_low = 1'b1;
      ext_bclk   = 1'b0;
      ext_fsync  = 1'b1;
      fs_gen_en  = 1'b0;
      @(negedge clk);
      fs_gen_en  = 1'b1;
      for (int i = 0; i < 40; i++) begin
         logic prev, es_sof;
         @(negedge clk);
         es_sof = 1'b0;
         if (i >= 2 && (i % 2) == 0) begin
            prev   = m;
            m      = (ext_pin(i - 1) == 1'b0);
            es_sof = m & ~prev;
         end
         if (bclk_en !== ((i % 2) == 1) || sof !== es_sof || fsx !== m || fsr !== ~m) bad++;
         if (sof === 1'b1) sofs++;
         ext_bclk  = ((i % 2) == 0);
         ext_fsync = ext_pin(i);
      end
      chk(bad == 0, "R10 external sync follow, mismatches", bad, 0);
      chk(sofs == 2, "R10 external sync start strobes", sofs, 2);
      cfg_mode   = 2'b00;
      cfg_rx_low = 1'b0;
      ext_bclk   = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_divider();
      t_free_run();
      t_clamp();
      t_polarity();
      t_boundary();
      t_load();
      t_enables();
      t_ext_clk();
      t_ext_sync();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule